// File: doc/BRIEF.md
# Dual Video Input Selector and Power Controller

This block decides which of two video input paths, analog or digital, owns a shared output stage. It then drives the power enables of each circuit domain to match that choice. It watches a small group of analog activity flags and one clock-activity flag that comes from an external detector. It also reads three control bits from a register file: a global power-on bit, an override bit and an interface-select bit. From these it produces a registered active-interface code and the per-domain enables.

The activity flags are asynchronous. Each one passes through a two-flop synchronizer and then a stability filter, so a flag must hold its new level for a set number of cycles before the selection logic sees it. When the selection moves straight from analog to digital, the block raises a hot-plug-detect control output for a fixed number of cycles. This lets the system force the attached source to renegotiate the link. The length of that pulse defaults to 100 ms at the system clock.

Top module: `vsel_power_ctrl`

## Requirements
- R1: After reset `active_o` is 2'b00 (none), every domain enable, `sync_det_o` and `hpd_o` are 0, and `serial_en_o` is 1.
- R2: With `pwr_on_i`=1 and `ovr_i`=0, analog activity counts as present when any bit of `ana_flags_i` is 1. When only analog activity is present, `active_o` becomes 2'b01 (analog).
- R3: With `pwr_on_i`=1 and `ovr_i`=0, when only `dig_clk_act_i` is 1 (clock active), `active_o` becomes 2'b10 (digital).
- R4: With `pwr_on_i`=1, `ovr_i`=0 and both activities present, `sel_i`=0 gives analog and `sel_i`=1 gives digital.
- R5: With `pwr_on_i`=1 and `ovr_i`=1, `sel_i` alone chooses: 0 gives analog and 1 gives digital, whatever the activity flags are.
- R6: With `pwr_on_i`=0, or with `pwr_on_i`=1, `ovr_i`=0 and no activity present, `active_o` is 2'b00 and `sync_det_o` is 0.
- R7: `ana_pwr_en_o` is 1 only while analog is active, and `dig_pwr_en_o` is 1 only while digital is active. `hsync_en_o`, `sog_en_o`, `outdrv_en_o`, `bgap_en_o` and `sync_det_o` are 1 whenever either interface is active. `serial_en_o` is always 1.
- R8: A direct change of `active_o` from analog to digital raises `hpd_o` for exactly HPD_CYCLES cycles, starting in the same cycle as the change.
- R9: A new analog-to-digital change while `hpd_o` is high restarts the full HPD_CYCLES count.
- R10: A change from digital to analog, or any change to none, never raises `hpd_o`.
- R11: A change on an activity flag that lasts fewer than STABLE_CYCLES cycles after synchronization has no effect on `active_o`. A level held longer is acted on.
- R12: Changes of `ovr_i`, `sel_i` and `pwr_on_i` reach the outputs one clock edge later. An activity-flag change reaches them STABLE_CYCLES+3 edges later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ana_flags_i | input | ANA_FLAGS | Asynchronous analog activity flags |
| dig_clk_act_i | input | 1 | Asynchronous digital clock-activity flag, 1 = active |
| ovr_i | input | 1 | Override: the select bit alone decides |
| sel_i | input | 1 | Interface select / priority, 0 = analog, 1 = digital |
| pwr_on_i | input | 1 | Global power-on, 0 = everything down |
| active_o | output | 2 | Active interface: 00 none, 01 analog, 10 digital |
| ana_pwr_en_o | output | 1 | Analog path power enable |
| dig_pwr_en_o | output | 1 | Digital path power enable |
| hsync_en_o | output | 1 | Horizontal sync detect power enable |
| sog_en_o | output | 1 | Sync-on-green slicer power enable |
| outdrv_en_o | output | 1 | Shared output driver enable |
| bgap_en_o | output | 1 | Bandgap reference enable |
| serial_en_o | output | 1 | Serial control bus enable, always 1 |
| sync_det_o | output | 1 | Sync detect output, 0 when no interface is active |
| hpd_o | output | 1 | Hot-plug-detect control pulse |

## Verification
The assertions check on every cycle that the two path enables are never both on and that the shared enables follow the active code. They also check that the pulse output rises only on a direct analog-to-digital step, and that the first rising cycle always follows such a step. The filter assertion checks that a filtered flag only ever takes the value its synchronizer held one cycle earlier. The bench scenarios are needed for the full selection truth table, the exact pulse length and its restart, glitch rejection, and the latency from each input.

// File: rtl/vsel_pkg.sv
package vsel_pkg;
   typedef enum logic [1:0] {
      ACT_NONE    = 2'b00,
      ACT_ANALOG  = 2'b01,
      ACT_DIGITAL = 2'b10
   } active_t;
endpackage

// File: rtl/vsel_sync_filter.sv
module vsel_sync_filter #(
   parameter int unsigned STABLE_CYCLES = 16
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic d_i,
   output logic q_o
);
   localparam int unsigned CW = (STABLE_CYCLES < 2) ? 1 : $clog2(STABLE_CYCLES);

   logic s1_q, s2_q, filt_q;

   if (STABLE_CYCLES < 1) begin : g_bad_param
      $error("vsel_sync_filter: STABLE_CYCLES must be at least 1");
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         s1_q <= 1'b0;
         s2_q <= 1'b0;
      end else begin
         s1_q <= d_i;
         s2_q <= s1_q;
      end
   end

   if (STABLE_CYCLES == 1) begin : g_direct
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) filt_q <= 1'b0;
         else         filt_q <= s2_q;
      end
   end else begin : g_counted
      logic [CW-1:0] cnt_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            cnt_q  <= '0;
            filt_q <= 1'b0;
         end else if (s2_q == filt_q) begin
            cnt_q <= '0;
         end else if (cnt_q == CW'(STABLE_CYCLES - 1)) begin
            cnt_q  <= '0;
            filt_q <= s2_q;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   assign q_o = filt_q;

   // R11: a filtered level only moves to what the synchronizer held before
   assert_filter_follows_sync_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (filt_q != $past(filt_q)) |-> (filt_q == $past(s2_q)));
endmodule

// File: rtl/vsel_decide.sv
module vsel_decide
   import vsel_pkg::*;
(
   input  logic    ana_act_i,
   input  logic    dig_act_i,
   input  logic    ovr_i,
   input  logic    sel_i,
   input  logic    pwr_on_i,
   output active_t pick_o
);
   always_comb begin
      pick_o = ACT_NONE;
      if (pwr_on_i) begin
         if (ovr_i) begin
            pick_o = sel_i ? ACT_DIGITAL : ACT_ANALOG;
         end else begin
            unique case ({ana_act_i, dig_act_i})
               2'b10:   pick_o = ACT_ANALOG;
               2'b01:   pick_o = ACT_DIGITAL;
               2'b11:   pick_o = sel_i ? ACT_DIGITAL : ACT_ANALOG;
               default: pick_o = ACT_NONE;
            endcase
         end
      end
   end
endmodule

// File: rtl/vsel_hpd_pulse.sv
module vsel_hpd_pulse #(
   parameter int unsigned CYCLES = 25_000_000
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic trig_i,
   output logic pulse_o
);
   localparam int unsigned CW = $clog2(CYCLES + 1);

   logic [CW-1:0] cnt_q;

   if (CYCLES < 1) begin : g_bad_param
      $error("vsel_hpd_pulse: CYCLES must be at least 1");
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)              cnt_q <= '0;
      else if (trig_i)          cnt_q <= CW'(CYCLES);
      else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
   end

   assign pulse_o = (cnt_q != '0);

   // R9: a trigger always leaves the pulse asserted on the next cycle
   assert_trigger_loads_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      trig_i |=> pulse_o);
endmodule

// File: rtl/vsel_power_ctrl.sv
module vsel_power_ctrl
   import vsel_pkg::*;
#(
   parameter int unsigned ANA_FLAGS     = 3,
   parameter int unsigned STABLE_CYCLES = 16,
   parameter int unsigned CLK_HZ        = 250_000_000,
   parameter int unsigned HPD_MS        = 100,
   parameter int unsigned HPD_CYCLES    = (CLK_HZ / 1000) * HPD_MS
) (
   input  logic                 clk_i,
   input  logic                 rst_ni,
   input  logic [ANA_FLAGS-1:0] ana_flags_i,
   input  logic                 dig_clk_act_i,
   input  logic                 ovr_i,
   input  logic                 sel_i,
   input  logic                 pwr_on_i,
   output logic [1:0]           active_o,
   output logic                 ana_pwr_en_o,
   output logic                 dig_pwr_en_o,
   output logic                 hsync_en_o,
   output logic                 sog_en_o,
   output logic                 outdrv_en_o,
   output logic                 bgap_en_o,
   output logic                 serial_en_o,
   output logic                 sync_det_o,
   output logic                 hpd_o
);
   localparam int unsigned NIN = ANA_FLAGS + 1;

   if (ANA_FLAGS < 1) begin : g_bad_flags
      $error("vsel_power_ctrl: ANA_FLAGS must be at least 1");
   end

   logic [NIN-1:0] raw_act, filt_act;
   active_t        pick, act_q;
   logic           ana_en_q, dig_en_q, shared_q;
   logic           hpd_trig;

   assign raw_act = {dig_clk_act_i, ana_flags_i};

   for (genvar i = 0; i < NIN; i++) begin : g_in
      vsel_sync_filter #(.STABLE_CYCLES(STABLE_CYCLES)) u_filt (
         .clk_i  (clk_i),
         .rst_ni (rst_ni),
         .d_i    (raw_act[i]),
         .q_o    (filt_act[i])
      );
   end

   vsel_decide u_decide (
      .ana_act_i (|filt_act[ANA_FLAGS-1:0]),
      .dig_act_i (filt_act[ANA_FLAGS]),
      .ovr_i     (ovr_i),
      .sel_i     (sel_i),
      .pwr_on_i  (pwr_on_i),
      .pick_o    (pick)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         act_q    <= ACT_NONE;
         ana_en_q <= 1'b0;
         dig_en_q <= 1'b0;
         shared_q <= 1'b0;
      end else begin
         act_q    <= pick;
         ana_en_q <= (pick == ACT_ANALOG);
         dig_en_q <= (pick == ACT_DIGITAL);
         shared_q <= (pick != ACT_NONE);
      end
   end

   assign hpd_trig = (act_q == ACT_ANALOG) && (pick == ACT_DIGITAL);

   vsel_hpd_pulse #(.CYCLES(HPD_CYCLES)) u_hpd (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .trig_i  (hpd_trig),
      .pulse_o (hpd_o)
   );

   assign active_o     = act_q;
   assign ana_pwr_en_o = ana_en_q;
   assign dig_pwr_en_o = dig_en_q;
   assign hsync_en_o   = shared_q;
   assign sog_en_o     = shared_q;
   assign outdrv_en_o  = shared_q;
   assign bgap_en_o    = shared_q;
   assign sync_det_o   = shared_q;
   assign serial_en_o  = 1'b1;

   // R7: never both path domains powered
   assert_one_path_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0({ana_pwr_en_o, dig_pwr_en_o}));
   // R7: shared enables agree with the active code
   assert_shared_match_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      shared_q == (ana_en_q | dig_en_q));
   assert_code_match_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ana_en_q == (act_q == ACT_ANALOG)) && (dig_en_q == (act_q == ACT_DIGITAL)));
   // R6: power-off forces none on the next edge
   assert_off_none_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !pwr_on_i |=> (active_o == ACT_NONE && !sync_det_o));
   // R8: analog to digital step raises the pulse in the same cycle
   assert_hpd_on_step_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (act_q == ACT_ANALOG && pick == ACT_DIGITAL) |=> hpd_o);
   // R10: the pulse only starts on an analog to digital step
   assert_hpd_cause_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(hpd_o) |-> ($past(act_q) == ACT_ANALOG && act_q == ACT_DIGITAL));
endmodule

// File: tb/vsel_power_ctrl_tb.sv
module vsel_power_ctrl_tb;
   import vsel_pkg::*;

   localparam int unsigned NF     = 3;
   localparam int unsigned STABLE = 4;
   localparam int unsigned HPDN   = 8;
   localparam int unsigned SETTLE = STABLE + 6;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NF-1:0] flags = '0;
   logic          dig = 1'b0, ovr = 1'b0, sel = 1'b0, pwr = 1'b0;
   logic [1:0]    active;
   logic          ana_en, dig_en, hs_en, sog_en, od_en, bg_en, ser_en, sdet, hpd;

   int total = 0;
   int bad = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;

   vsel_power_ctrl #(
      .ANA_FLAGS(NF), .STABLE_CYCLES(STABLE), .HPD_CYCLES(HPDN)
   ) u_dut (
      .clk_i(clk), .rst_ni(rst_n), .ana_flags_i(flags), .dig_clk_act_i(dig),
      .ovr_i(ovr), .sel_i(sel), .pwr_on_i(pwr), .active_o(active),
      .ana_pwr_en_o(ana_en), .dig_pwr_en_o(dig_en), .hsync_en_o(hs_en),
      .sog_en_o(sog_en), .outdrv_en_o(od_en), .bgap_en_o(bg_en),
      .serial_en_o(ser_en), .sync_det_o(sdet), .hpd_o(hpd)
   );

   task automatic check(string req, int act, int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wait_n(int n);
      repeat (n) @(negedge clk);
   endtask

   // expected {ana,dig,hsync,sog,outdrv,bgap,serial,sync} for a given code
   function automatic logic [7:0] enables_for(logic [1:0] a);
      logic any;
      any = (a != 2'b00);
      return {a == 2'b01, a == 2'b10, any, any, any, any, 1'b1, any};
   endfunction

   task automatic expect_state(string req, logic [1:0] exp);
      check(req, active, exp);
      check({req, "/R7"}, {ana_en, dig_en, hs_en, sog_en, od_en, bg_en, ser_en, sdet},
            enables_for(exp));
   endtask

   task automatic count_pulse(output int n);
      n = 0;
      while (hpd && n < 64) begin
         n++;
         @(negedge clk);
      end
   endtask

   task automatic t_reset;
      @(negedge clk);
      expect_state("R1 reset", 2'b00);
      check("R1 hpd", hpd, 0);
      rst_n = 1'b1;
      wait_n(2);
   endtask

   task automatic t_analog_only;
      pwr = 1'b1; ovr = 1'b0; dig = 1'b0;
      for (int b = 0; b < NF; b++) begin
         flags = '0; wait_n(SETTLE);
         expect_state("R6 no activity", 2'b00);
         flags = NF'(1) << b; wait_n(SETTLE);
         expect_state("R2 analog flag", 2'b01);
      end
      flags = '0; wait_n(SETTLE);
   endtask

   task automatic t_digital_only;
      dig = 1'b1; wait_n(SETTLE);
      expect_state("R3 digital only", 2'b10);
      check("R10 drop none no pulse", hpd, 0);
      dig = 1'b0;
      for (int k = 0; k < SETTLE; k++) begin
         @(negedge clk);
         check("R10 no pulse to none", hpd, 0);
      end
      expect_state("R6 back to none", 2'b00);
   endtask

   task automatic t_latency;
      // flag change reaches output at edge STABLE+3
      flags = 3'b010;
      wait_n(STABLE + 2);
      check("R12 not yet", active, 2'b00);
      wait_n(1);
      check("R12 flag latency", active, 2'b01);
      sel = 1'b1; ovr = 1'b1;
      wait_n(1);
      check("R12 register latency", active, 2'b10);
      wait_n(HPDN + 2);
      ovr = 1'b0; sel = 1'b0; flags = '0; wait_n(SETTLE);
   endtask

   task automatic t_both;
      flags = 3'b100; dig = 1'b1; sel = 1'b0; wait_n(SETTLE);
      expect_state("R4 both sel0", 2'b01);
      sel = 1'b1; wait_n(1);
      expect_state("R4 both sel1", 2'b10);
      wait_n(HPDN + 2);
   endtask

   task automatic t_override;
      ovr = 1'b1; flags = '0; dig = 1'b0; sel = 1'b0; wait_n(SETTLE);
      expect_state("R5 override analog", 2'b01);
      sel = 1'b1; flags = 3'b001; wait_n(SETTLE);
      expect_state("R5 override digital", 2'b10);
      wait_n(HPDN + 2);
   endtask

   task automatic t_power_off;
      pwr = 1'b0; ovr = 1'b1; sel = 1'b1; flags = 3'b111; dig = 1'b1; wait_n(2);
      expect_state("R6 power off", 2'b00);
      check("R6 sync det", sdet, 0);
      check("R7 serial on", ser_en, 1);
      ovr = 1'b0; wait_n(SETTLE);
      expect_state("R6 power off no ovr", 2'b00);
   endtask

   task automatic t_hpd;
      int n;
      pwr = 1'b1; ovr = 1'b1; sel = 1'b0; flags = '0; dig = 1'b0; wait_n(SETTLE);
      check("R10 idle no pulse", hpd, 0);
      sel = 1'b1;
      @(negedge clk);
      check("R8 same cycle code", active, 2'b10);
      count_pulse(n);
      check("R8 pulse length", n, HPDN);
      sel = 1'b0;
      for (int k = 0; k < 4; k++) begin
         @(negedge clk);
         check("R10 dig to ana no pulse", hpd, 0);
      end
      check("R10 analog reached", active, 2'b01);
   endtask

   task automatic t_retrigger;
      int n;
      sel = 1'b1; wait_n(3);
      check("R9 high before restart", hpd, 1);
      sel = 1'b0; wait_n(1);
      check("R9 still high on analog", hpd, 1);
      sel = 1'b1; wait_n(1);
      count_pulse(n);
      check("R9 restarted length", n, HPDN);
      sel = 1'b0; wait_n(2);
   endtask

   task automatic t_glitch;
      ovr = 1'b0; sel = 1'b0; flags = '0; dig = 1'b0; wait_n(SETTLE);
      flags = 3'b010; wait_n(STABLE - 2); flags = '0;
      for (int k = 0; k < SETTLE; k++) begin
         @(negedge clk);
         check("R11 analog glitch ignored", active, 2'b00);
      end
      dig = 1'b1; wait_n(STABLE - 2); dig = 1'b0;
      for (int k = 0; k < SETTLE; k++) begin
         @(negedge clk);
         check("R11 digital glitch ignored", active, 2'b00);
      end
      dig = 1'b1; wait_n(SETTLE);
      check("R11 held level accepted", active, 2'b10);
   endtask

   initial begin
      t_reset();
      t_analog_only();
      t_digital_only();
      t_latency();
      t_both();
      t_override();
      t_power_off();
      t_hpd();
      t_retrigger();
      t_glitch();
      if (!finished) begin
         finished = 1'b1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         total++;
         bad++;
         $display("FAIL watchdog: actual=hung expected=done");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule